// File: doc/BRIEF.md
# Character-Stream Instruction Assembler

This block turns a stream of ASCII characters, delivered one byte per strobe (for instance by a serial receiver), into 16-bit instruction words for a small stack processor. Decimal digits build a number in an accumulator. A single class letter then combines that number with an opcode class and produces a finished jump, conditional jump, call or literal word at once. Punctuation and a few letters fill the fields of an arithmetic/stack word instead. A space or line feed then releases that word.

Every emitted word appears on the output bus with a valid strobe that lasts one cycle. It comes in the cycle after the character that completed it was accepted. At most one word is produced per character. Characters the block does not recognise are dropped, and idle cycles change nothing.

Top module: `char_insn_asm`

## Requirements
- R1: After synchronous reset, `insn_valid` is low, the accumulator holds 0 and no arithmetic word is pending. A terminator sent first produces no word, and a class letter sent first produces a target of 0.
- R2: Each digit character '0'..'9' updates the accumulator to acc*10 + digit, modulo 2^ACC_W.
- R3: 'j' emits 0x0000 | (acc & 0x1FFF), 'z' emits 0x2000 | (acc & 0x1FFF) and 'c' emits 0x4000 | (acc & 0x1FFF).
- R4: '#' emits 0x8000 | (acc & 0x7FFF).
- R5: Every class letter clears the accumulator, so a following class letter with no digits uses 0.
- R6: Operation characters write bits [11:8] of the pending word: 't'=0, 'n'=1, '+'=2, '&'=3, '|'=4, '^'=5, '~'=6, '='=7, '>'=8, '@'=0xC, 'u'=0xF. The last one received wins.
- R7: '(' writes bits [1:0] to 01 and ')' writes them to 11. '[' writes bits [3:2] to 01 and ']' writes them to 11.
- R8: 'N' sets bit 7 and 'R' sets bit 6 of the pending word. Both may be set together.
- R9: A space (0x20) or line feed (0x0A) emits a pending word as 0x6000 | fields, then clears the word and the accumulator. Without a pending word it only clears the accumulator.
- R10: Unrecognised characters and cycles with `char_valid` low do not alter the accumulator, the pending word or the output.
- R11: `insn_valid` is a single-cycle pulse in the cycle after the accepted character, with at most one word per character.
- R12: A class letter received while an arithmetic word is pending leaves that pending word intact, so it is still emitted by the next terminator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_valid | input | 1 | Strobe: `char_data` holds a character this cycle |
| char_data | input | 8 | ASCII character |
| insn_valid | output | 1 | One-cycle strobe for a finished word |
| insn_data | output | 16 | Assembled instruction word |

## Verification
The bench builds the block with the default 16-bit accumulator. With that width a five-digit number such as 70000 wraps, so accumulator overflow can be reached with short input strings. Targets above 8191 and literals above 32767 exercise the 13-bit and 15-bit masks. Interleaved class letters and terminators cover the ordering rules between the two word kinds.

// File: rtl/casm_pkg.sv
package casm_pkg;

    localparam int WORD_W = 16;
    localparam logic [WORD_W-1:0] TGT_MASK = 16'h1FFF;
    localparam logic [WORD_W-1:0] LIT_MASK = 16'h7FFF;

    typedef enum logic [2:0] {
        CK_NONE, CK_DIGIT, CK_CLASS, CK_ALUOP,
        CK_DSTK, CK_RSTK, CK_XFER, CK_TERM
    } ck_kind_e;

    typedef struct packed {
        ck_kind_e           kind;
        logic [3:0]         val;   // digit, op code, stack code or transfer bits
        logic [WORD_W-1:0]  base;  // class base for class letters
        logic [WORD_W-1:0]  mask;  // operand mask for class letters
    } ck_dec_t;

    typedef struct packed {
        logic [3:0] op;
        logic [1:0] xfer;  // [1] top->next, [0] top->return
        logic [1:0] rstk;
        logic [1:0] dstk;
    } alu_fields_t;

    function automatic logic [WORD_W-1:0] alu_word(input alu_fields_t f);
        return {3'b011, 1'b0, f.op, f.xfer, 2'b00, f.rstk, f.dstk};
    endfunction

    function automatic ck_dec_t decode_char(input logic [7:0] c);
        ck_dec_t d;
        d = '{kind: CK_NONE, val: 4'h0, base: '0, mask: '0};
        if (c >= 8'h30 && c <= 8'h39) begin
            d.kind = CK_DIGIT;
            d.val  = c[3:0];
        end else begin
            case (c)
                "j": begin d.kind = CK_CLASS; d.base = 16'h0000; d.mask = TGT_MASK; end
                "z": begin d.kind = CK_CLASS; d.base = 16'h2000; d.mask = TGT_MASK; end
                "c": begin d.kind = CK_CLASS; d.base = 16'h4000; d.mask = TGT_MASK; end
                "#": begin d.kind = CK_CLASS; d.base = 16'h8000; d.mask = LIT_MASK; end
                "t": begin d.kind = CK_ALUOP; d.val = 4'h0; end
                "n": begin d.kind = CK_ALUOP; d.val = 4'h1; end
                "+": begin d.kind = CK_ALUOP; d.val = 4'h2; end
                "&": begin d.kind = CK_ALUOP; d.val = 4'h3; end
                "|": begin d.kind = CK_ALUOP; d.val = 4'h4; end
                "^": begin d.kind = CK_ALUOP; d.val = 4'h5; end
                "~": begin d.kind = CK_ALUOP; d.val = 4'h6; end
                "=": begin d.kind = CK_ALUOP; d.val = 4'h7; end
                ">": begin d.kind = CK_ALUOP; d.val = 4'h8; end
                "@": begin d.kind = CK_ALUOP; d.val = 4'hC; end
                "u": begin d.kind = CK_ALUOP; d.val = 4'hF; end
                "(": begin d.kind = CK_DSTK;  d.val = 4'h1; end
                ")": begin d.kind = CK_DSTK;  d.val = 4'h3; end
                "[": begin d.kind = CK_RSTK;  d.val = 4'h1; end
                "]": begin d.kind = CK_RSTK;  d.val = 4'h3; end
                "N": begin d.kind = CK_XFER;  d.val = 4'h2; end
                "R": begin d.kind = CK_XFER;  d.val = 4'h1; end
                8'h20, 8'h0A: d.kind = CK_TERM;
                default: d.kind = CK_NONE;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/casm_accum.sv
module casm_accum #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [3:0]       digit,
    input  logic             clear,
    output logic [ACC_W-1:0] acc
);
    localparam logic [ACC_W-1:0] TEN = ACC_W'(10);

    always_ff @(posedge clk) begin
        if (rst || clear)
            acc <= '0;
        else if (step)
            acc <= acc * TEN + ACC_W'(digit);
    end

    assert_digit_step_R2: assert property (@(posedge clk) disable iff (rst)
        (step && !clear) |=> acc == $past(acc) * TEN + ACC_W'($past(digit)));

    assert_acc_cleared_R5: assert property (@(posedge clk) disable iff (rst)
        clear |=> acc == '0);

endmodule

// File: rtl/casm_alu_builder.sv
module casm_alu_builder
    import casm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_en,
    input  logic              dstk_en,
    input  logic              rstk_en,
    input  logic              xfer_en,
    input  logic [3:0]        code,
    input  logic              clear,
    output logic              pending,
    output logic [WORD_W-1:0] word
);
    alu_fields_t fields;
    logic        touch;

    assign touch = op_en || dstk_en || rstk_en || xfer_en;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fields  <= '0;
            pending <= 1'b0;
        end else if (touch) begin
            pending <= 1'b1;
            if (op_en)   fields.op   <= code;
            if (dstk_en) fields.dstk <= code[1:0];
            if (rstk_en) fields.rstk <= code[1:0];
            if (xfer_en) fields.xfer <= fields.xfer | code[1:0];
        end
    end

    assign word = alu_word(fields);

    assert_term_clears_R9: assert property (@(posedge clk) disable iff (rst)
        clear |=> !pending);

    assert_touch_pends_R6: assert property (@(posedge clk) disable iff (rst)
        (touch && !clear) |=> pending);

endmodule

// File: rtl/char_insn_asm.sv
module char_insn_asm
    import casm_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              char_valid,
    input  logic [7:0]        char_data,
    output logic              insn_valid,
    output logic [WORD_W-1:0] insn_data
);
    ck_dec_t             dec;
    logic                is_digit, is_class, is_term;
    logic [ACC_W-1:0]    acc;
    logic [WORD_W-1:0]   acc_w;
    logic                pending;
    logic [WORD_W-1:0]   alu_w;

    assign dec      = decode_char(char_data);
    assign is_digit = char_valid && dec.kind == CK_DIGIT;
    assign is_class = char_valid && dec.kind == CK_CLASS;
    assign is_term  = char_valid && dec.kind == CK_TERM;
    assign acc_w    = WORD_W'(acc);

    casm_accum #(.ACC_W(ACC_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .step  (is_digit),
        .digit (dec.val),
        .clear (is_class || is_term),
        .acc   (acc)
    );

    casm_alu_builder u_alu (
        .clk     (clk),
        .rst     (rst),
        .op_en   (char_valid && dec.kind == CK_ALUOP),
        .dstk_en (char_valid && dec.kind == CK_DSTK),
        .rstk_en (char_valid && dec.kind == CK_RSTK),
        .xfer_en (char_valid && dec.kind == CK_XFER),
        .code    (dec.val),
        .clear   (is_term),
        .pending (pending),
        .word    (alu_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            insn_valid <= 1'b0;
            insn_data  <= '0;
        end else begin
            insn_valid <= 1'b0;
            if (is_class) begin
                insn_valid <= 1'b1;
                insn_data  <= dec.base | (acc_w & dec.mask);
            end else if (is_term && pending) begin
                insn_valid <= 1'b1;
                insn_data  <= alu_w;
            end
        end
    end

    assert_valid_follows_char_R11: assert property (@(posedge clk) disable iff (rst)
        insn_valid |-> $past(char_valid));

    assert_literal_msb_R4: assert property (@(posedge clk) disable iff (rst)
        (char_valid && char_data == "#") |=> (insn_valid && insn_data[15]));

    assert_jump_class_R3: assert property (@(posedge clk) disable iff (rst)
        (char_valid && char_data == "j") |=> (insn_valid && insn_data[15:13] == 3'b000));

    assert_term_alu_class_R9: assert property (@(posedge clk) disable iff (rst)
        (is_term && pending) |=> (insn_valid && insn_data[15:12] == 4'h6));

endmodule

// File: tb/sim_char_insn_asm.sv
module sim_char_insn_asm;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        char_valid = 1'b0;
    logic [7:0]  char_data = 8'h00;
    logic        insn_valid;
    logic [15:0] insn_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;   // 125 MHz

    char_insn_asm #(.ACC_W(16)) u0 (
        .clk(clk), .rst(rst), .char_valid(char_valid), .char_data(char_data),
        .insn_valid(insn_valid), .insn_data(insn_data)
    );

    task automatic report_end();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic expect_word(input logic [15:0] w, input string tag);
        exp_q.push_back(w);
        tag_q.push_back(tag);
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) begin
            @(negedge clk);
            char_valid = 1'b1;
            char_data  = s[i];
            @(negedge clk);
            char_valid = 1'b0;
        end
    endtask

    // monitor: pop expected words as the design produces them
    always @(negedge clk) begin
        if (!rst && insn_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R11 unexpected word actual=%h expected=none", insn_data);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (insn_data !== e) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", t, insn_data, e);
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d cycles expected=done", cycles);
            report_end();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (insn_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset valid actual=%b expected=0", insn_valid);
        end
        // R1: terminator with nothing pending emits nothing; fresh class uses 0
        send_str(" ");
        expect_word(16'h0000, "R1 fresh jump");           send_str("j");
        // R2 / R3
        expect_word(16'h007B, "R2 R3 jump 123");          send_str("123j");
        expect_word(16'h0328, "R3 jump mask 9000");       send_str("9000j");
        expect_word(16'h2005, "R3 cond jump 5");          send_str("5z");
        expect_word(16'h4064, "R3 call 100");             send_str("100c");
        // R4
        expect_word(16'hFFFF, "R4 literal 65535");        send_str("65535#");
        expect_word(16'h9C40, "R4 literal 40000");        send_str("40000#");
        expect_word(16'h9170, "R2 wrap 70000");           send_str("70000#");
        // R5
        expect_word(16'h200C, "R5 before clear");         send_str("12z");
        expect_word(16'h0000, "R5 cleared");              send_str("j");
        // R6
        expect_word(16'h6300, "R6 last op wins");         send_str("+& ");
        expect_word(16'h6000, "R6 t");                    send_str("t ");
        expect_word(16'h6100, "R6 n");                    send_str("n ");
        expect_word(16'h6400, "R6 |");                    send_str("| ");
        expect_word(16'h6500, "R6 ^");                    send_str("^ ");
        expect_word(16'h6600, "R6 ~ LF");                 send_str("~\n");
        expect_word(16'h6700, "R6 =");                    send_str("= ");
        expect_word(16'h6800, "R6 >");                    send_str("> ");
        expect_word(16'h6F00, "R6 u");                    send_str("u ");
        // R7
        expect_word(16'h6001, "R7 push ds");              send_str("( ");
        expect_word(16'h6003, "R7 pop ds");               send_str(") ");
        expect_word(16'h6004, "R7 push rs");              send_str("[ ");
        expect_word(16'h600C, "R7 pop rs");               send_str("] ");
        expect_word(16'h600D, "R7 mix");                  send_str("(] ");
        // R8
        expect_word(16'h6080, "R8 N");                    send_str("N ");
        expect_word(16'h6040, "R8 R");                    send_str("R ");
        expect_word(16'h60C0, "R8 NR");                   send_str("NR ");
        expect_word(16'h6C83, "R6 R7 R8 combined");       send_str("@N) ");
        // R9: terminator clears accumulator and word
        expect_word(16'h6200, "R9 emit");                 send_str("+12 ");
        expect_word(16'h0000, "R9 acc cleared");          send_str("j");
        expect_word(16'h000E, "R9 term without pending"); send_str("7 14j");
        // R10: unknown characters and idle cycles
        expect_word(16'h002F, "R10 ignore x");            send_str("4x7j");
        expect_word(16'h6180, "R10 ignore Q ?");          send_str("Qn?N\n");
        send_str("3");
        repeat (5) @(negedge clk);
        expect_word(16'h0021, "R10 idle cycles");         send_str("3j");
        // R12: class letter leaves pending ALU word intact
        expect_word(16'h4007, "R12 class mid ALU");
        expect_word(16'h6200, "R12 pending kept");        send_str("+7c ");
        // R11: back-to-back characters give one pulse each
        expect_word(16'h0001, "R11 first");
        expect_word(16'h0000, "R11 second");              send_str("1jj");
        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R11 missing words actual=%0d expected=0", exp_q.size());
        end
        report_end();
    end

endmodule